// File: doc/BRIEF.md
# CAN Test-Mode Bit Router

This block sits between a CAN protocol core and the transceiver pins and applies the test-mode routing used for self-test and passive bus monitoring. Two stored configuration bits, a listen-only bit and a self-feedback bit, select one of four operating variants: plain pass-through, listen-only, self-feedback, or both together. For each bit time it decides what reaches the transmit pin and what the core sees as its receive bit. It also decides whether the core may begin a transmission and whether an acknowledge error reported by the core is forwarded.

The two configuration bits can only be written while the controller reports initialization mode. Writes at any other time are dropped. The routing takes effect once the controller leaves initialization mode. While in initialization mode the transmit pin is held recessive and no transmission may start. The protocol engine, message filtering and storage are outside this block. The core is represented only by its transmit bit, its receive bit, its transmission-start request and its acknowledge-error flag.

Top module: `can_test_path`

## Requirements
- R1: After reset both configuration bits read 0 (`cfg_listen_q` = 0, `cfg_loop_q` = 0), which selects pass-through routing.
- R2: When `cfg_wr_en` is 1 and `init_mode` is 1 at a clock edge, `cfg_listen_q` and `cfg_loop_q` take `cfg_listen_d` and `cfg_loop_d` after that edge. When `cfg_wr_en` is 1 and `init_mode` is 0, both stored bits keep their value.
- R3: While `init_mode` is 1, `pin_tx` is 1 (recessive), `tx_start_ok` is 0, `core_rx` equals `pin_rx`, and `ack_err_out` equals `core_ack_err`, whatever the stored configuration.
- R4: When `init_mode` is 0 and `cfg_listen_q` is 1, `pin_tx` is 1 for every value of `core_tx`.
- R5: In listen-only operation (`init_mode`=0, listen=1, loop=0), `tx_start_ok` is 0, `core_rx` equals `pin_rx` AND `core_tx` (dominant is 0), and `ack_err_out` equals `core_ack_err`.
- R6: When `init_mode` is 0 and `cfg_loop_q` is 1, `core_rx` equals `core_tx` whatever `pin_rx` is, and `ack_err_out` is 0.
- R7: In self-feedback-only operation (`init_mode`=0, listen=0, loop=1), `pin_tx` equals `core_tx` and `tx_start_ok` equals `core_tx_req`.
- R8: With both bits set and `init_mode` 0, `tx_start_ok` equals `core_tx_req`, while `pin_tx` stays 1 (R4) and `core_rx` follows `core_tx` (R6).
- R9: In pass-through operation (`init_mode`=0, both bits 0), `pin_tx` equals `core_tx`, `core_rx` equals `pin_rx`, `tx_start_ok` equals `core_tx_req` and `ack_err_out` equals `core_ack_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_mode | input | 1 | Controller is in initialization mode |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_listen_d | input | 1 | Listen-only bit to write |
| cfg_loop_d | input | 1 | Self-feedback bit to write |
| core_tx | input | 1 | Bit the core wants to send (0 = dominant) |
| core_tx_req | input | 1 | Core asks to start a transmission |
| core_ack_err | input | 1 | Core reports a missing acknowledge |
| pin_rx | input | 1 | Receive pin from the transceiver |
| pin_tx | output | 1 | Transmit pin to the transceiver |
| core_rx | output | 1 | Receive bit presented to the core |
| tx_start_ok | output | 1 | Transmission start permitted |
| ack_err_out | output | 1 | Acknowledge error forwarded to the core |
| cfg_listen_q | output | 1 | Stored listen-only bit |
| cfg_loop_q | output | 1 | Stored self-feedback bit |

## Verification
Every stored configuration plus initialization mode is combined with all sixteen values of `core_tx`, `pin_rx`, `core_tx_req` and `core_ack_err`. This shows whether the receive bit follows the pin, the core's own bit, or their wired AND. A dominant core bit against a recessive pin separates listen-only feedback from plain pass-through. A dominant pin against a recessive core bit shows that self-feedback ignores the pin. Configuration writes are attempted both inside and outside initialization mode, and the readback shows which writes were kept.

// File: rtl/can_tp_pkg.sv
// Package: shared mode encoding for the CAN test-path block.
package can_tp_pkg;
    // Operating variant derived from init state and the two config bits.
    typedef enum logic [2:0] {
        TP_INIT     = 3'd0,
        TP_NORMAL   = 3'd1,
        TP_LISTEN   = 3'd2,
        TP_LOOP     = 3'd3,
        TP_LOOP_LSN = 3'd4
    } tp_mode_e;

    localparam logic BIT_RECESSIVE = 1'b1;
endpackage

// File: rtl/can_tp_cfg_reg.sv
// Module: can_tp_cfg_reg
// Holds the listen-only and self-feedback bits. A write is accepted only
// while the controller reports initialization mode; other writes are dropped.
// Assumes init_mode is synchronous to clk.
module can_tp_cfg_reg #(
    parameter logic RST_LISTEN = 1'b0,
    parameter logic RST_LOOP   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_mode,
    input  logic wr_en,
    input  logic listen_d,
    input  logic loop_d,
    output logic listen_q,
    output logic loop_q
);
    logic wr_ok;
    assign wr_ok = wr_en && init_mode;

    // Capture the config bits on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            listen_q <= RST_LISTEN;
            loop_q   <= RST_LOOP;
        end else if (wr_ok) begin
            listen_q <= listen_d;
            loop_q   <= loop_d;
        end
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (listen_q == RST_LISTEN && loop_q == RST_LOOP));
    assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && init_mode) |=> (listen_q == $past(listen_d) && loop_q == $past(loop_d)));
    assert_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode) |=> ($stable(listen_q) && $stable(loop_q)));
endmodule

// File: rtl/can_tp_mode_dec.sv
// Module: can_tp_mode_dec
// Turns initialization state and the stored bits into one operating variant.
// Initialization mode overrides the stored bits.
module can_tp_mode_dec
    import can_tp_pkg::*;
(
    input  logic     init_mode,
    input  logic     listen,
    input  logic     loop,
    output tp_mode_e mode
);
    // Pick the variant; init wins over configuration.
    always_comb begin
        if (init_mode)            mode = TP_INIT;
        else if (listen && loop)  mode = TP_LOOP_LSN;
        else if (loop)            mode = TP_LOOP;
        else if (listen)          mode = TP_LISTEN;
        else                      mode = TP_NORMAL;
    end
endmodule

// File: rtl/can_tp_bit_router.sv
// Module: can_tp_bit_router
// Routes the core's transmit bit and the receive pin for the selected variant,
// gates transmission starts and masks acknowledge errors. Purely combinational;
// assumes dominant is 0 and the bus is a wired AND.
module can_tp_bit_router
    import can_tp_pkg::*;
(
    input  tp_mode_e mode,
    input  logic     core_tx,
    input  logic     core_tx_req,
    input  logic     core_ack_err,
    input  logic     pin_rx,
    output logic     pin_tx,
    output logic     core_rx,
    output logic     tx_start_ok,
    output logic     ack_err_out
);
    // Select pin drive, core receive bit, start permission and ack masking.
    always_comb begin
        pin_tx      = BIT_RECESSIVE;
        core_rx     = pin_rx;
        tx_start_ok = 1'b0;
        ack_err_out = core_ack_err;
        unique case (mode)
            TP_INIT: begin
                pin_tx      = BIT_RECESSIVE;
                tx_start_ok = 1'b0;
            end
            TP_NORMAL: begin
                pin_tx      = core_tx;
                tx_start_ok = core_tx_req;
            end
            TP_LISTEN: begin
                core_rx     = pin_rx & core_tx;
                tx_start_ok = 1'b0;
            end
            TP_LOOP: begin
                pin_tx      = core_tx;
                core_rx     = core_tx;
                tx_start_ok = core_tx_req;
                ack_err_out = 1'b0;
            end
            TP_LOOP_LSN: begin
                core_rx     = core_tx;
                tx_start_ok = core_tx_req;
                ack_err_out = 1'b0;
            end
            default: begin
                pin_tx      = BIT_RECESSIVE;
                tx_start_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/can_test_path.sv
// Module: can_test_path (top)
// Test-mode routing between a CAN core and its transceiver pins: config
// register, mode decode and bit router. Assumes all inputs synchronous to clk.
module can_test_path
    import can_tp_pkg::*;
#(
    parameter logic RST_LISTEN = 1'b0,
    parameter logic RST_LOOP   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_mode,
    input  logic cfg_wr_en,
    input  logic cfg_listen_d,
    input  logic cfg_loop_d,
    input  logic core_tx,
    input  logic core_tx_req,
    input  logic core_ack_err,
    input  logic pin_rx,
    output logic pin_tx,
    output logic core_rx,
    output logic tx_start_ok,
    output logic ack_err_out,
    output logic cfg_listen_q,
    output logic cfg_loop_q
);
    tp_mode_e mode;

    can_tp_cfg_reg #(.RST_LISTEN(RST_LISTEN), .RST_LOOP(RST_LOOP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .wr_en(cfg_wr_en),
        .listen_d(cfg_listen_d), .loop_d(cfg_loop_d),
        .listen_q(cfg_listen_q), .loop_q(cfg_loop_q)
    );

    can_tp_mode_dec u_dec (
        .init_mode(init_mode), .listen(cfg_listen_q), .loop(cfg_loop_q), .mode(mode)
    );

    can_tp_bit_router u_rt (
        .mode(mode), .core_tx(core_tx), .core_tx_req(core_tx_req),
        .core_ack_err(core_ack_err), .pin_rx(pin_rx), .pin_tx(pin_tx),
        .core_rx(core_rx), .tx_start_ok(tx_start_ok), .ack_err_out(ack_err_out)
    );

    assert_init_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |-> (pin_tx && !tx_start_ok && core_rx == pin_rx));
    assert_listen_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && cfg_listen_q) |-> pin_tx);
    assert_listen_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && cfg_listen_q && !cfg_loop_q) |-> (!tx_start_ok && core_rx == (pin_rx & core_tx)));
    assert_loop_feedback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && cfg_loop_q) |-> (core_rx == core_tx && !ack_err_out));
    assert_loop_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && !cfg_listen_q && cfg_loop_q) |-> (pin_tx == core_tx));
    assert_both_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && cfg_listen_q && cfg_loop_q) |-> (tx_start_ok == core_tx_req));
    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && !cfg_listen_q && !cfg_loop_q) |-> (pin_tx == core_tx && core_rx == pin_rx));
endmodule

// File: tb/can_test_path_tb.sv
// Bench: sweeps every configuration and every core/pin input combination.
module can_test_path_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_mode = 1'b1, cfg_wr_en = 1'b0, cfg_listen_d = 1'b0, cfg_loop_d = 1'b0;
    logic core_tx = 1'b1, core_tx_req = 1'b0, core_ack_err = 1'b0, pin_rx = 1'b1;
    logic pin_tx, core_rx, tx_start_ok, ack_err_out, cfg_listen_q, cfg_loop_q;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    can_test_path u_dut (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cfg_wr_en(cfg_wr_en),
        .cfg_listen_d(cfg_listen_d), .cfg_loop_d(cfg_loop_d), .core_tx(core_tx),
        .core_tx_req(core_tx_req), .core_ack_err(core_ack_err), .pin_rx(pin_rx),
        .pin_tx(pin_tx), .core_rx(core_rx), .tx_start_ok(tx_start_ok),
        .ack_err_out(ack_err_out), .cfg_listen_q(cfg_listen_q), .cfg_loop_q(cfg_loop_q)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic inm, input logic ls, input logic lp);
        @(negedge clk);
        init_mode = inm; cfg_wr_en = 1'b1; cfg_listen_d = ls; cfg_loop_d = lp;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Sweep the 16 input combinations for a given state; expected values from the rules.
    task automatic sweep(input logic inm, input logic ls, input logic lp, input string tag);
        init_mode = inm;
        for (int v = 0; v < 16; v++) begin
            logic e_tx, e_rx, e_ok, e_ack;
            core_tx = v[0]; pin_rx = v[1]; core_tx_req = v[2]; core_ack_err = v[3];
            #1;
            if (inm) begin
                e_tx = 1'b1; e_rx = pin_rx; e_ok = 1'b0; e_ack = core_ack_err;
            end else begin
                e_tx  = ls ? 1'b1 : core_tx;
                e_rx  = lp ? core_tx : (ls ? (pin_rx & core_tx) : pin_rx);
                e_ok  = (ls && !lp) ? 1'b0 : core_tx_req;
                e_ack = lp ? 1'b0 : core_ack_err;
            end
            chk({tag, " pin_tx"}, pin_tx, e_tx);
            chk({tag, " core_rx"}, core_rx, e_rx);
            chk({tag, " tx_start_ok"}, tx_start_ok, e_ok);
            chk({tag, " ack_err_out"}, ack_err_out, e_ack);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 listen reset", cfg_listen_q, 1'b0);
        chk("R1 loop reset", cfg_loop_q, 1'b0);
        sweep(1'b1, 1'b0, 1'b0, "R3 init");
        sweep(1'b0, 1'b0, 1'b0, "R9 pass");

        // Write outside init must be dropped (R2).
        write_cfg(1'b0, 1'b1, 1'b1);
        chk("R2 dropped listen", cfg_listen_q, 1'b0);
        chk("R2 dropped loop", cfg_loop_q, 1'b0);

        for (int m = 1; m < 4; m++) begin
            logic ls, lp;
            ls = m[0]; lp = m[1];
            write_cfg(1'b1, ls, lp);
            chk("R2 taken listen", cfg_listen_q, ls);
            chk("R2 taken loop", cfg_loop_q, lp);
            sweep(1'b1, ls, lp, "R3 init cfg");
            if (ls && !lp)      sweep(1'b0, ls, lp, "R4 R5 listen");
            else if (!ls && lp) sweep(1'b0, ls, lp, "R6 R7 loop");
            else                sweep(1'b0, ls, lp, "R4 R6 R8 both");
            write_cfg(1'b0, ~ls, ~lp);
            chk("R2 kept listen", cfg_listen_q, ls);
            chk("R2 kept loop", cfg_loop_q, lp);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule